// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Load-Use Stall Logic

This block is the hazard logic of a five-stage in-order pipeline. It resolves operand forwarding during decode, not at the ALU input. For each of the two source registers of the instruction being decoded, it looks at the three instructions further down the pipe, in EX, MEM and WB. It then picks where the operand must come from.

Each choice is a 2-bit select. The select steers a four-input multiplexer that loads the A or B operand register. The four inputs are the register file read data, the EX result, the MEM result and the WB result.

A load in EX cannot supply its data to the instruction right behind it. In that case the block raises a stall. The surrounding pipeline uses the stall to hold the PC and the instruction register for one cycle, and to inject an all-zero control bubble into EX. On the next cycle the load sits in MEM and the select picks the MEM path.

The block is purely combinational. It has no clock and no reset.

Top module: `hz_decode_fwd`

## Requirements
- R1: When no downstream stage qualifies for a source register, that operand's select is 0 (register file). A stage qualifies when its write enable is set, its destination number equals the source number, and the source number is nonzero.
- R2: When the EX-stage instruction qualifies, the select is 1.
- R3: When MEM qualifies and EX does not, the select is 2.
- R4: When only WB qualifies, the select is 3.
- R5: When several stages qualify at once, the youngest wins, in the order EX, then MEM, then WB. With all three matching, the select is 1.
- R6: A source register number of 0 always gives select 0, even when a stage writes register 0 with its write enable set.
- R7: A stage whose write enable is low never affects a select, even when its destination number matches.
- R8: The A select is computed only from the first source number (bits of `src_a_idx`). The B select is computed only from the second source number (`src_b_idx`). The two are independent.
- R9: `stall` is 1 exactly when `ex_mem_rd` is 1 and either select equals 1.
- R10: `stall` stays 0 in two cases: when the EX instruction is not a load, and when a load in EX is not the chosen producer for either operand. The second case covers a load whose destination matches a source only in MEM or WB, and a load with its write enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | 5 | First source register number of the decoding instruction |
| src_b_idx | input | 5 | Second source register number of the decoding instruction |
| ex_dst_idx | input | 5 | Destination register number of the EX-stage instruction |
| ex_wr_en | input | 1 | Register write enable of the EX-stage instruction |
| ex_mem_rd | input | 1 | EX-stage instruction reads data memory (load) |
| mem_dst_idx | input | 5 | Destination register number of the MEM-stage instruction |
| mem_wr_en | input | 1 | Register write enable of the MEM-stage instruction |
| wb_dst_idx | input | 5 | Destination register number of the WB-stage instruction |
| wb_wr_en | input | 1 | Register write enable of the WB-stage instruction |
| fwd_sel_a | output | 2 | A operand mux select: 0 regfile, 1 EX, 2 MEM, 3 WB |
| fwd_sel_b | output | 2 | B operand mux select: 0 regfile, 1 EX, 2 MEM, 3 WB |
| stall | output | 1 | Load-use stall: hold PC and instruction register, inject bubble into EX |

## Verification
The hardest situations to reach from the ports are the overlap cases. One is all three stages writing the same nonzero register that a source names. Another is a match that comes only from a disabled stage or from register 0. A third is a load whose result is shadowed by nothing yet is wanted by only one of the two operands.

The stimulus reaches all of these by sweeping every source and destination number over a small alphabet that includes register 0. It covers every combination of the three write enables and the load flag. The result is that every coincidence of equal numbers across stages and operands appears. A final directed pass uses register 31 to reach the top of the index range.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int REG_IDX_W = 5;
    localparam int NUM_PROD  = 3;
    localparam int SEL_W     = $clog2(NUM_PROD + 1);

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef enum logic [SEL_W-1:0] {
        FWD_RF  = 2'd0,
        FWD_EX  = 2'd1,
        FWD_MEM = 2'd2,
        FWD_WB  = 2'd3
    } fwd_sel_t;

    typedef struct packed {
        reg_idx_t dst;
        logic     wr_en;
    } producer_t;

    // A producer supplies the operand only when it writes a real register
    // that equals the requested source.
    function automatic logic prod_hits(input reg_idx_t src, input producer_t p);
        return p.wr_en && (src != '0) && (src == p.dst);
    endfunction

endpackage

// File: rtl/hz_match_vec.sv
module hz_match_vec
    import hz_pkg::*;
(
    input  reg_idx_t               src,
    input  producer_t              prod [NUM_PROD],
    output logic [NUM_PROD-1:0]    hit
);
    for (genvar i = 0; i < NUM_PROD; i++) begin : g_stage
        assign hit[i] = prod_hits(src, prod[i]);
    end
endmodule

// File: rtl/hz_prio_sel.sv
module hz_prio_sel
    import hz_pkg::*;
(
    input  logic [NUM_PROD-1:0] hit,
    output fwd_sel_t            sel
);
    // Index 0 is the youngest producer (EX); scan from oldest so the
    // youngest hit is written last and wins.
    always_comb begin
        sel = FWD_RF;
        for (int i = NUM_PROD - 1; i >= 0; i--) begin
            if (hit[i]) sel = fwd_sel_t'(i + 1);
        end
    end
endmodule

// File: rtl/hz_load_stall.sv
module hz_load_stall
    import hz_pkg::*;
(
    input  logic     ex_is_load,
    input  fwd_sel_t sel_a,
    input  fwd_sel_t sel_b,
    output logic     stall
);
    assign stall = ex_is_load && ((sel_a == FWD_EX) || (sel_b == FWD_EX));
endmodule

// File: rtl/hz_decode_fwd.sv
module hz_decode_fwd
    import hz_pkg::*;
(
    input  logic [4:0] src_a_idx,
    input  logic [4:0] src_b_idx,
    input  logic [4:0] ex_dst_idx,
    input  logic       ex_wr_en,
    input  logic       ex_mem_rd,
    input  logic [4:0] mem_dst_idx,
    input  logic       mem_wr_en,
    input  logic [4:0] wb_dst_idx,
    input  logic       wb_wr_en,
    output logic [1:0] fwd_sel_a,
    output logic [1:0] fwd_sel_b,
    output logic       stall
);
    localparam int NUM_OPND = 2;

    producer_t prod [NUM_PROD];
    reg_idx_t  src  [NUM_OPND];
    fwd_sel_t  sel  [NUM_OPND];

    assign prod[0] = '{dst: ex_dst_idx,  wr_en: ex_wr_en};
    assign prod[1] = '{dst: mem_dst_idx, wr_en: mem_wr_en};
    assign prod[2] = '{dst: wb_dst_idx,  wr_en: wb_wr_en};
    assign src[0]  = src_a_idx;
    assign src[1]  = src_b_idx;

    for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
        logic [NUM_PROD-1:0] hit;
        hz_match_vec u_match (.src(src[k]), .prod(prod), .hit(hit));
        hz_prio_sel  u_sel   (.hit(hit), .sel(sel[k]));
    end

    hz_load_stall u_stall (
        .ex_is_load (ex_mem_rd),
        .sel_a      (sel[0]),
        .sel_b      (sel[1]),
        .stall      (stall)
    );

    assign fwd_sel_a = sel[0];
    assign fwd_sel_b = sel[1];

    always_comb begin
        // R6
        zero_src_chk: assert (src_a_idx != '0 || fwd_sel_a == 2'd0);
        // R2
        ex_first_chk: assert (!(ex_wr_en && src_b_idx != '0 && src_b_idx == ex_dst_idx)
                              || fwd_sel_b == 2'd1);
        // R7
        mem_wr_gate_chk: assert (fwd_sel_a != 2'd2 || (mem_wr_en && mem_dst_idx == src_a_idx));
        // R4
        wb_wr_gate_chk: assert (fwd_sel_b != 2'd3 || (wb_wr_en && wb_dst_idx == src_b_idx));
        // R9
        stall_cause_chk: assert (!stall || (ex_mem_rd && ex_wr_en && ex_dst_idx != '0 &&
                                 (src_a_idx == ex_dst_idx || src_b_idx == ex_dst_idx)));
    end
endmodule

// File: tb/tb_hz_decode_fwd.sv
module tb_hz_decode_fwd;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [4:0] src_a_idx, src_b_idx, ex_dst_idx, mem_dst_idx, wb_dst_idx;
    logic ex_wr_en, ex_mem_rd, mem_wr_en, wb_wr_en;
    logic [1:0] fwd_sel_a, fwd_sel_b;
    logic stall;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    hz_decode_fwd dut (.*);

    // Behavioural model: walk producers from youngest to oldest.
    function automatic int model_sel(int s);
        int d[3]; bit w[3];
        d[0] = ex_dst_idx; d[1] = mem_dst_idx; d[2] = wb_dst_idx;
        w[0] = ex_wr_en;   w[1] = mem_wr_en;   w[2] = wb_wr_en;
        if (s == 0) return 0;
        for (int i = 0; i < 3; i++) if (w[i] && d[i] == s) return i + 1;
        return 0;
    endfunction

    function automatic string sel_tag(int s, int exp);
        int n = 0; bit disabled_eq = 0;
        if (ex_dst_idx == s && ex_wr_en) n++;
        if (mem_dst_idx == s && mem_wr_en) n++;
        if (wb_dst_idx == s && wb_wr_en) n++;
        disabled_eq = (ex_dst_idx == s && !ex_wr_en) || (mem_dst_idx == s && !mem_wr_en) ||
                      (wb_dst_idx == s && !wb_wr_en);
        if (s == 0) return "R6";
        if (n > 1) return "R5";
        if (exp == 1) return "R2";
        if (exp == 2) return "R3";
        if (exp == 3) return "R4";
        if (disabled_eq) return "R7";
        return "R1";
    endfunction

    task automatic check_all();
        int ea, eb; bit es;
        ea = model_sel(src_a_idx);
        eb = model_sel(src_b_idx);
        es = ex_mem_rd && (ea == 1 || eb == 1);
        checks += 3;
        if (fwd_sel_a != ea[1:0]) begin
            failures++;
            $display("FAIL %s sel_a actual=%0d expected=%0d", sel_tag(src_a_idx, ea), fwd_sel_a, ea);
        end
        if (fwd_sel_b != eb[1:0]) begin
            failures++;
            $display("FAIL R8 %s sel_b actual=%0d expected=%0d", sel_tag(src_b_idx, eb), fwd_sel_b, eb);
        end
        if (stall != es) begin
            failures++;
            $display("FAIL %s stall actual=%0d expected=%0d", es ? "R9" : "R10", stall, es);
        end
    endtask

    task automatic apply(int a, int b, int d2, int d3, int d4, bit w2, bit w3, bit w4, bit rd);
        @(posedge clk); #1;
        src_a_idx = 5'(a); src_b_idx = 5'(b);
        ex_dst_idx = 5'(d2); mem_dst_idx = 5'(d3); wb_dst_idx = 5'(d4);
        ex_wr_en = w2; mem_wr_en = w3; wb_wr_en = w4; ex_mem_rd = rd;
        @(negedge clk);
        check_all();
    endtask

    initial begin
        apply(0, 0, 0, 0, 0, 0, 0, 0, 0);              // R1 idle state
        apply(7, 9, 7, 7, 7, 1, 1, 1, 1);              // R5 all three match, R9 stall
        apply(7, 9, 3, 7, 7, 1, 1, 1, 1);              // R3 MEM wins, R10 no stall
        apply(0, 0, 0, 0, 0, 1, 1, 1, 1);              // R6 writes to register 0
        apply(9, 7, 7, 1, 9, 0, 1, 1, 1);              // R7 disabled EX, R4 WB
        for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
        for (int d2 = 0; d2 < 4; d2++)
        for (int d3 = 0; d3 < 4; d3++)
        for (int d4 = 0; d4 < 4; d4++)
        for (int f = 0; f < 16; f++)
            apply(a, b, d2, d3, d4, f[0], f[1], f[2], f[3]);
        for (int f = 0; f < 16; f++)                   // top of the index range
            apply(31, 30, 31, 30, 31, f[0], f[1], f[2], f[3]);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule